// File: doc/BRIEF.md
# FM Synthesis Register Front End with Slot-Timed Busy

This block is the host write port of an FM synthesis core that serves six channels in turn. The host presents an address, a data byte and a bank select. Each write is sorted into one of three groups. Global registers in the 0x20..0x2F window take effect at once. Per-channel and per-operator registers (0x30..0xFF) are held as a single pending write. Everything else is discarded.

A pending write raises BUSY. It is released to the datapath as a one-cycle commit strobe when the time-multiplexed sequencer reaches that channel's slot. The block divides the clock by six to form the internal processing tick. A slot index input stands in for the sequencer, so BUSY lasts a variable time that depends on where the slot rotation is.

The global group also holds the following:
- the 10-bit reload value for timer A and the 8-bit reload value for timer B;
- the timer control bits and overflow flags;
- the key-on field;
- the 9-bit direct sample.

The block also produces a status byte and an interrupt line.

Top module: `fm_reg_frontend`

## Requirements
- R1: After reset, busy_o, irq_o, status_o, dac_o, keyon_o and commit_valid_o are all 0.
- R2: A write to an address in 0x30..0xFF whose bits 1:0 are 0, 1 or 2 is accepted while BUSY is clear. BUSY is set from the next cycle. The target channel is bits 1:0 plus 3 when bank_i is 1.
- R3: The internal tick is high in every sixth clock cycle, starting with the sixth cycle after reset. In a tick cycle where BUSY is set and slot_i equals the pending channel, commit_valid_o is high and commit_ch_o, commit_addr_o and commit_data_o carry the pending write. BUSY is clear from the next cycle.
- R4: A per-channel write that arrives while BUSY is set is dropped. The pending write and the later commit are unchanged.
- R5: Global writes are accepted while BUSY is set. dac_o[8:1] is the last data written to 0x2A, and dac_o[0] is bit 3 of the last data written to 0x2C.
- R6: A write to 0x28 stores data bits 7:4 in keyon_o[5:2] and data bits 1:0 in keyon_o[1:0]. Data bits 3:2 are discarded.
- R7: The following writes change no output and leave BUSY clear: addresses below 0x20, unused addresses in 0x20..0x2F (for example 0x2F), and per-channel addresses whose bits 1:0 equal 3.
- R8: Timer A reloads from {0x24, 0x25 bits 1:0}. While 0x27 bit 0 is 1, it advances once per tick and wraps after 1023. On the wrap it sets flag A if 0x27 bit 2 is 1. With reload R, flag A is set after exactly 1024-R ticks.
- R9: Timer B reloads from 0x26. While 0x27 bit 1 is 1, it advances once every 16 ticks and wraps after 255. On the wrap it sets flag B if 0x27 bit 3 is 1. With reload R, flag B is set after exactly 16*(256-R) ticks.
- R10: A write to 0x27 with bit 4 set clears flag A, and with bit 5 set clears flag B.
- R11: status_o bit 7 is BUSY, bit 1 is flag B and bit 0 is flag A; all other bits are 0. irq_o is flag A AND flag B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| bank_i | input | 1 | Channel bank select (0: channels 0-2, 1: channels 3-5) |
| addr_i | input | 8 | Register address |
| data_i | input | 8 | Write data |
| slot_i | input | 3 | Channel slot currently being processed by the sequencer |
| busy_o | output | 1 | A per-channel write is pending |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt: both timer flags set |
| dac_o | output | 9 | Direct sample value |
| keyon_o | output | 6 | Stored key-on bits |
| commit_valid_o | output | 1 | Pending write released this cycle |
| commit_ch_o | output | 3 | Channel of the released write |
| commit_addr_o | output | 8 | Address of the released write |
| commit_data_o | output | 8 | Data of the released write |

## Verification
The sweep covers every combination of bank and low address bits across several addresses and data values. Idle gaps of varying length shift each write against the slot rotation, so a commit that fires one tick early or late, or on the wrong channel, stands out from the correct one. A reference model of BUSY and commit is compared in every cycle, and it separates timing errors from channel-mapping errors. Back-to-back per-channel writes tell dropping apart from overwriting. Global writes issued while BUSY is held prove the gating covers only the per-channel range. Timer reloads chosen close to the wrap point make the overflow tick count exact in both directions, one tick before and at the wrap.

// File: rtl/fm_fe_pkg.sv
`timescale 1ns/1ps
package fm_fe_pkg;
  localparam int NUM_CH      = 6;
  localparam int CH_PER_BANK = NUM_CH / 2;
  localparam int SLOT_W      = $clog2(NUM_CH);
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 8;
  localparam int CLK_DIV     = 6;
  localparam int TA_W        = 10;
  localparam int TB_W        = 8;
  localparam int TB_PRE_W    = 4;
  localparam int KEY_W       = 6;
  localparam logic [3:0] GLOBAL_HI = 4'h2;
  localparam logic [ADDR_W-1:0] CHAN_BASE = 8'h30;

  typedef enum logic [1:0] {
    AK_NONE   = 2'd0,
    AK_GLOBAL = 2'd1,
    AK_CHAN   = 2'd2
  } addr_kind_e;
endpackage

// File: rtl/fm_fe_decode.sv
`timescale 1ns/1ps
module fm_fe_decode
  import fm_fe_pkg::*;
(
  input  logic              bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  output addr_kind_e        kind_o,
  output logic [SLOT_W-1:0] ch_o
);
  logic [1:0] lo;
  assign lo = addr_i[1:0];

  always_comb begin
    kind_o = AK_NONE;
    if (addr_i[ADDR_W-1:ADDR_W-4] == GLOBAL_HI)
      kind_o = AK_GLOBAL;
    else if (addr_i >= CHAN_BASE && int'(lo) < CH_PER_BANK)
      kind_o = AK_CHAN;
    ch_o = SLOT_W'(lo) + (bank_i ? SLOT_W'(CH_PER_BANK) : SLOT_W'(0));
  end
endmodule

// File: rtl/fm_fe_pending.sv
`timescale 1ns/1ps
module fm_fe_pending
  import fm_fe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              req_i,
  input  logic [SLOT_W-1:0] req_ch_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              busy_o,
  output logic              commit_o,
  output logic [SLOT_W-1:0] commit_ch_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [DATA_W-1:0] commit_data_o
);
  logic              busy_q;
  logic [SLOT_W-1:0] pend_ch_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;

  // release only when the sequencer reaches the owning channel
  assign commit_o = busy_q & tick_i & (slot_i == pend_ch_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      pend_ch_q   <= '0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else if (req_i && !busy_q) begin
      busy_q      <= 1'b1;
      pend_ch_q   <= req_ch_i;
      pend_addr_q <= req_addr_i;
      pend_data_q <= req_data_i;
    end else if (commit_o) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o        = busy_q;
  assign commit_ch_o   = pend_ch_q;
  assign commit_addr_o = pend_addr_q;
  assign commit_data_o = pend_data_q;

  p_busy_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_q |=> busy_q && pend_ch_q == $past(req_ch_i));
  p_commit_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !busy_q);
  p_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !commit_o |=> busy_q && $stable(pend_ch_q)
      && $stable(pend_addr_q) && $stable(pend_data_q));
endmodule

// File: rtl/fm_fe_timer.sv
`timescale 1ns/1ps
module fm_fe_timer #(
  parameter int CNT_W = 10,
  parameter int PRE_W = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             flag_en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             flag_o
);
  logic             step;
  logic             wrap;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  generate
    if (PRE_W == 0) begin : g_direct
      assign step = tick_i & run_i;
    end else begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pre_q <= '0;
        else if (!run_i) pre_q <= '0;
        else if (tick_i) pre_q <= pre_q + 1'b1;
      end
      assign step = tick_i & run_i & (pre_q == '1);
    end
  endgenerate

  assign wrap = step & (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= reload_i;
    else if (step)   cnt_q <= wrap ? reload_i : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (clr_i)             flag_q <= 1'b0;
    else if (wrap && flag_en_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

  p_flag_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(run_i) && $past(flag_en_i));
  p_flag_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_q);
endmodule

// File: rtl/fm_reg_frontend.sv
`timescale 1ns/1ps
module fm_reg_frontend
  import fm_fe_pkg::*;
#(
  parameter int DIV      = CLK_DIV,
  parameter int TB_PRE   = TB_PRE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              busy_o,
  output logic [7:0]        status_o,
  output logic              irq_o,
  output logic [DATA_W:0]   dac_o,
  output logic [KEY_W-1:0]  keyon_o,
  output logic              commit_valid_o,
  output logic [SLOT_W-1:0] commit_ch_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [DATA_W-1:0] commit_data_o
);
  localparam int DIV_W = $clog2(DIV);
  localparam int TA_HI = TA_W - 2;

  // internal processing tick
  logic [DIV_W-1:0] div_q;
  logic             tick;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         div_q <= '0;
    else if (div_q == DIV_W'(DIV - 1))   div_q <= '0;
    else                                 div_q <= div_q + 1'b1;
  end
  assign tick = (div_q == DIV_W'(DIV - 1));

  addr_kind_e        kind;
  logic [SLOT_W-1:0] wr_ch;
  fm_fe_decode u_decode (
    .bank_i (bank_i),
    .addr_i (addr_i),
    .kind_o (kind),
    .ch_o   (wr_ch)
  );

  logic g_we, c_we;
  assign g_we = wr_en_i && kind == AK_GLOBAL;
  assign c_we = wr_en_i && kind == AK_CHAN;

  // global registers: never gated by busy
  logic [TA_HI-1:0]  ta_hi_q;
  logic [1:0]        ta_lo_q;
  logic [TB_W-1:0]   tb_q;
  logic [3:0]        ctrl_q;
  logic [KEY_W-1:0]  keyon_q;
  logic [DATA_W-1:0] dac_hi_q;
  logic              dac_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ta_hi_q  <= '0;
      ta_lo_q  <= '0;
      tb_q     <= '0;
      ctrl_q   <= '0;
      keyon_q  <= '0;
      dac_hi_q <= '0;
      dac_lo_q <= 1'b0;
    end else if (g_we) begin
      case (addr_i[3:0])
        4'h4: ta_hi_q  <= data_i[DATA_W-1:DATA_W-TA_HI];
        4'h5: ta_lo_q  <= data_i[1:0];
        4'h6: tb_q     <= data_i[TB_W-1:0];
        4'h7: ctrl_q   <= data_i[3:0];
        4'h8: keyon_q  <= {data_i[7:4], data_i[1:0]};
        4'hA: dac_hi_q <= data_i;
        4'hC: dac_lo_q <= data_i[3];
        default: ;
      endcase
    end
  end

  logic clr_a, clr_b;
  assign clr_a = g_we && addr_i[3:0] == 4'h7 && data_i[4];
  assign clr_b = g_we && addr_i[3:0] == 4'h7 && data_i[5];

  logic flag_a, flag_b;
  fm_fe_timer #(.CNT_W(TA_W), .PRE_W(0)) u_timer_a (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .run_i     (ctrl_q[0]),
    .flag_en_i (ctrl_q[2]),
    .clr_i     (clr_a),
    .reload_i  ({ta_hi_q, ta_lo_q}),
    .flag_o    (flag_a)
  );
  fm_fe_timer #(.CNT_W(TB_W), .PRE_W(TB_PRE)) u_timer_b (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .run_i     (ctrl_q[1]),
    .flag_en_i (ctrl_q[3]),
    .clr_i     (clr_b),
    .reload_i  (tb_q),
    .flag_o    (flag_b)
  );

  logic busy;
  fm_fe_pending u_pending (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .slot_i        (slot_i),
    .req_i         (c_we),
    .req_ch_i      (wr_ch),
    .req_addr_i    (addr_i),
    .req_data_i    (data_i),
    .busy_o        (busy),
    .commit_o      (commit_valid_o),
    .commit_ch_o   (commit_ch_o),
    .commit_addr_o (commit_addr_o),
    .commit_data_o (commit_data_o)
  );

  assign busy_o   = busy;
  assign status_o = {busy, 5'b0, flag_b, flag_a};
  assign irq_o    = flag_a & flag_b;
  assign dac_o    = {dac_hi_q, dac_lo_q};
  assign keyon_o  = keyon_q;

  p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);
  p_dac_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == 8'h2A |=> dac_o[DATA_W:1] == $past(data_i));
  p_key_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == 8'h28 |=> keyon_o[1:0] == $past(data_i[1:0]));
  p_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i < 8'h20 |=> $stable(dac_o) && $stable(keyon_o));
endmodule

// File: tb/fm_reg_frontend_test.sv
`timescale 1ns/1ps
module fm_reg_frontend_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       wr_en = 1'b0, bank = 1'b0;
  logic [7:0] addr = '0, data = '0;
  logic [2:0] slot = '0;

  logic       busy_o, irq_o, commit_valid_o;
  logic [7:0] status_o, commit_addr_o, commit_data_o;
  logic [8:0] dac_o;
  logic [5:0] keyon_o;
  logic [2:0] commit_ch_o;

  fm_reg_frontend uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .bank_i(bank),
    .addr_i(addr), .data_i(data), .slot_i(slot),
    .busy_o(busy_o), .status_o(status_o), .irq_o(irq_o), .dac_o(dac_o),
    .keyon_o(keyon_o), .commit_valid_o(commit_valid_o), .commit_ch_o(commit_ch_o),
    .commit_addr_o(commit_addr_o), .commit_data_o(commit_data_o)
  );

  int n_chk = 0, n_fail = 0, n_commit = 0;
  bit done = 0;
  int ph = 0;
  logic [7:0] lc_data;
  logic [2:0] lc_ch;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // tick phase: tick cycle when ph == 5
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ph <= 0; else ph <= (ph == 5) ? 0 : ph + 1;

  always @(posedge clk)
    if (rst_n && ph == 5) slot <= #1 ((slot == 3'd5) ? 3'd0 : slot + 3'd1);

  function automatic bit is_chan(input logic [7:0] a);
    return a >= 8'h30 && a[1:0] != 2'd3;
  endfunction

  // reference model of busy / pending write
  logic       m_busy = 1'b0;
  logic [2:0] m_ch = '0;
  logic [7:0] m_addr = '0, m_data = '0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_busy <= 1'b0;
    else begin
      if (m_busy && ph == 5 && slot == m_ch) m_busy <= 1'b0;
      if (wr_en && !m_busy && is_chan(addr)) begin
        m_busy <= 1'b1;
        m_ch   <= bank ? {1'b0, addr[1:0]} + 3'd3 : {1'b0, addr[1:0]};
        m_addr <= addr;
        m_data <= data;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_c;
      exp_c = m_busy && ph == 5 && slot == m_ch;
      chk(busy_o == m_busy, "R2/R4 busy", busy_o, m_busy);
      chk(commit_valid_o == exp_c, "R3 commit_valid", commit_valid_o, exp_c);
      if (exp_c) begin
        chk(commit_ch_o == m_ch, "R3 commit_ch", commit_ch_o, m_ch);
        chk(commit_addr_o == m_addr, "R3 commit_addr", commit_addr_o, m_addr);
        chk(commit_data_o == m_data, "R3 commit_data", commit_data_o, m_data);
      end
      if (commit_valid_o) begin
        n_commit++;
        lc_data = commit_data_o;
        lc_ch   = commit_ch_o;
      end
      chk(status_o[6:2] == 5'd0 && status_o[7] == busy_o, "R11 status busy/zero bits",
          status_o, {busy_o, 7'd0});
    end
  end

  task automatic wr(input logic b, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bank = b; addr = a; data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      while (ph != 5) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60 && busy_o; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(irq_o == 0, "R1 irq", irq_o, 0);
    chk(status_o == 0, "R1 status", status_o, 0);
    chk(dac_o == 0, "R1 dac", dac_o, 0);
    chk(keyon_o == 0, "R1 keyon", keyon_o, 0);
    chk(commit_valid_o == 0, "R1 commit", commit_valid_o, 0);

    // R2/R3 sweep over banks, low bits, addresses, alignments
    for (int p = 0; p < 3; p++) begin
      for (int b = 0; b < 2; b++) begin
        for (int lo = 0; lo < 4; lo++) begin
          int idx;
          logic [7:0] a;
          idx = p * 8 + b * 4 + lo;
          a = 8'h30 + 8'((idx * 20) % 200);
          a[1:0] = 2'(lo);
          repeat (idx % 7) @(negedge clk);
          wr(b[0], a, 8'(8'h5C ^ (idx * 37)));
          if (lo == 3) chk(busy_o == 0, "R7 low bits 3 ignored", busy_o, 0);
          else chk(busy_o == 1, "R2 busy after write", busy_o, 1);
          wait_idle();
          repeat (2) @(negedge clk);
        end
      end
    end
    chk(n_commit == 18, "R3 commit count", n_commit, 18);

    // R4 drop + R5 globals while busy
    begin
      int tgt, other, nc;
      @(negedge clk);
      tgt = (int'(slot) + 4) % 6;
      other = (tgt + 1) % 6;
      nc = n_commit;
      wr(tgt >= 3, 8'h50 + 8'(tgt % 3), 8'h11);
      wr(other >= 3, 8'h60 + 8'(other % 3), 8'h22);
      wr(1'b0, 8'h2A, 8'h5A);
      wr(1'b0, 8'h2C, 8'h08);
      chk(busy_o == 1, "R5 busy held during global writes", busy_o, 1);
      chk(dac_o == 9'h0B5, "R5 dac while busy", dac_o, 9'h0B5);
      wait_idle();
      repeat (2) @(negedge clk);
      chk(n_commit == nc + 1, "R4 single commit", n_commit, nc + 1);
      chk(lc_data == 8'h11, "R4 dropped write data", lc_data, 8'h11);
      chk(lc_ch == 3'(tgt), "R4 committed channel", lc_ch, tgt);
      wr(1'b1, 8'h2C, 8'h00);
      chk(dac_o == 9'h0B4, "R5 dac lsb clear", dac_o, 9'h0B4);
    end

    // R6 key-on
    wr(1'b0, 8'h28, 8'hFF);
    chk(keyon_o == 6'h3F, "R6 keyon all", keyon_o, 6'h3F);
    wr(1'b0, 8'h28, 8'h0C);
    chk(keyon_o == 6'h00, "R6 bits 3:2 discarded", keyon_o, 6'h00);
    wr(1'b0, 8'h28, 8'hA5);
    chk(keyon_o == 6'b101001, "R6 keyon pattern", keyon_o, 6'b101001);

    // R7 ignored addresses
    wr(1'b0, 8'h10, 8'hFF);
    wr(1'b0, 8'h2F, 8'hFF);
    wr(1'b1, 8'h00, 8'h33);
    wr(1'b0, 8'hFF, 8'h77);
    chk(busy_o == 0, "R7 busy stays clear", busy_o, 0);
    chk(keyon_o == 6'b101001, "R7 keyon unchanged", keyon_o, 6'b101001);
    chk(dac_o == 9'h0B4, "R7 dac unchanged", dac_o, 9'h0B4);
    chk(status_o == 8'h00, "R7 status unchanged", status_o, 0);

    // R8 timer A: reload 1020 -> 4 ticks
    wr(1'b0, 8'h24, 8'hFF);
    wr(1'b0, 8'h25, 8'h00);
    wr(1'b0, 8'h27, 8'h05);
    wait_ticks(3);
    chk(status_o[0] == 0, "R8 flag A before wrap", status_o[0], 0);
    wait_ticks(1);
    chk(status_o[0] == 1, "R8 flag A at wrap", status_o[0], 1);
    chk(status_o == 8'h01 && irq_o == 0, "R11 status A only", status_o, 8'h01);

    // R9 timer B: reload 0xFE -> 32 ticks
    wr(1'b0, 8'h26, 8'hFE);
    wr(1'b0, 8'h27, 8'h0A);
    wait_ticks(31);
    chk(status_o[1] == 0, "R9 flag B before wrap", status_o[1], 0);
    wait_ticks(1);
    chk(status_o[1] == 1, "R9 flag B at wrap", status_o[1], 1);
    chk(status_o == 8'h03, "R11 status both", status_o, 8'h03);
    chk(irq_o == 1, "R11 irq both flags", irq_o, 1);

    // R10 clears
    wr(1'b0, 8'h27, 8'h1A);
    chk(status_o == 8'h02, "R10 clear A", status_o, 8'h02);
    chk(irq_o == 0, "R11 irq after clear", irq_o, 0);
    wr(1'b0, 8'h27, 8'h20);
    chk(status_o == 8'h00, "R10 clear B", status_o, 8'h00);

    repeat (4) @(negedge clk);
    done = 1;
    summary();
  end
endmodule